// File: doc/BRIEF.md
# Token Allocation Manager for Shared Bus Targets

This block rations bus commands aimed at shared targets: sixteen memory banks and a small set of I/O ports. Each requester must win a token for the target before it may place a command on the bus. One token permits exactly one transaction of at most 128 bytes. Traffic between units that goes to no managed target does not pass through this block and needs no token.

Each requester is its own allocation group. For every pair of group and resource, the block holds a budget of tokens. The budget is refilled from a programmable allocation at every refill boundary, and the refill period in cycles is also programmable. Software may rewrite allocations and the period while traffic runs. A write lands in a staging copy and is applied at the next refill boundary, so the period already running stays intact. When a transaction ends, its token can be handed back. This tops the budget up again, but never above the active allocation. When several groups contend for one resource in the same cycle, a round-robin pointer for that resource picks the winner.

Top module: `tram_alloc_mgr`

## Requirements
- R1: After reset no grant or error is raised, every group's budget for every resource equals DEF_ALLOC (2), and the refill period is DEF_PERIOD (16) cycles, with the first refill 16 cycles after reset release.
- R2: The resource index is 5 bits: 0 to 15 select memory banks, and 16 to 16+NUM_IO-1 select I/O ports. A held request is granted in the same cycle, combinationally, while the group's budget for that resource is non-zero. Each grant consumes one token at the next clock edge, so a group receives at most its allocation of grants per period.
- R3: A request that meets an empty budget is neither dropped nor flagged. It waits, and it is granted in the first cycle after the next refill boundary.
- R4: Per resource, contending groups are served round-robin, starting after the last winner. After reset the pointer makes group 0 the first winner, then 1, 2, 3. At most one group is granted per resource per cycle.
- R5: Requests for different resources are granted in the same cycle, independently of each other.
- R6: A request with an index of 16+NUM_IO or above raises that requester's error flag in the same cycle, and it is never granted.
- R7: Config address {sel, group[1:0], res[4:0]} with sel=0 writes the allocation of that group and resource from wdata[3:0]. The write changes nothing in the running period. It becomes both the budget and the cap from the next refill boundary onward, and other groups are unaffected.
- R8: Config address with sel=1 (address 128) writes the refill period, which takes effect after the next boundary. A value of 0 behaves as 1, meaning a refill every cycle.
- R9: A token return pulse for (group, resource) adds one token to that budget. The budget saturates at the active allocation.
- R10: Budgets are reloaded to the allocation at every boundary, once per period, so a request held across a boundary receives fresh tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_REQ | Token request per requester, held until granted |
| req_res_i | input | NUM_REQ*5 | Resource index per requester, packed 5 bits each |
| req_gnt_o | output | NUM_REQ | Token grant, same cycle as the request |
| req_err_o | output | NUM_REQ | Resource index out of range |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1+GRP_W+5 | Configuration address {sel, group, resource} |
| cfg_wdata_i | input | PER_W | Configuration write data |
| ret_valid_i | input | 1 | Token return pulse |
| ret_grp_i | input | GRP_W | Group of the returned token |
| ret_res_i | input | 5 | Resource of the returned token |

## Verification
The bench sweeps every valid index with a single requester and every out-of-range index. This separates index decoding from budget accounting. Four groups hammering one bank show the rotation order cycle by cycle, and four groups on four different resources show that resources do not block each other. Requests held across boundaries, under periods of 16, 6 and 1, tell the refill timing apart from the deferral of period writes. Allocation rewrites are checked before and after a boundary, and bursts of returns are checked against an emptied and a full budget, which separates refunds from the saturation cap.

// File: rtl/tram_pkg.sv
package tram_pkg;
  // width of a resource index on the request side
  localparam int RES_W = 5;
  // number of memory banks behind the manager
  localparam int BANKS = 16;
endpackage

// File: rtl/tram_rr_arb.sv
module tram_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;
  logic          hit;

  always_comb begin
    gnt_o = '0;
    hit   = 1'b0;
    ptr_d = ptr_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!hit && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        hit        = 1'b1;
        ptr_d      = idx[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= IW'(N - 1);
    else if (hit) ptr_q <= ptr_d;
  end

  assert_single_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  assert_winner_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/tram_budget_slot.sv
module tram_budget_slot #(
  parameter int BUD_W     = 4,
  parameter int DEF_ALLOC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refill_i,
  input  logic             cfg_hit_i,
  input  logic [BUD_W-1:0] cfg_val_i,
  input  logic             take_i,
  input  logic             give_i,
  output logic             avail_o
);
  logic [BUD_W-1:0] stage_q, act_q, bud_q;
  logic [BUD_W-1:0] bud_d;
  logic [BUD_W:0]   sum;

  always_comb begin
    sum = {1'b0, bud_q} + {{BUD_W{1'b0}}, give_i} - {{BUD_W{1'b0}}, take_i};
    if (refill_i)                   bud_d = stage_q;
    else if (sum > {1'b0, act_q})   bud_d = act_q;
    else                            bud_d = sum[BUD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stage_q <= BUD_W'(DEF_ALLOC);
    else if (cfg_hit_i) stage_q <= cfg_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= BUD_W'(DEF_ALLOC);
    else if (refill_i) act_q <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bud_q <= BUD_W'(DEF_ALLOC);
    else        bud_q <= bud_d;
  end

  assign avail_o = (bud_q != '0);

  assert_take_needs_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> bud_q != '0);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bud_q <= act_q);
  assert_empty_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bud_q == '0 && !refill_i && !give_i) |=> bud_q == '0);
endmodule

// File: rtl/tram_period_timer.sv
module tram_period_timer #(
  parameter int PER_W      = 8,
  parameter int DEF_PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_wr_i,
  input  logic [PER_W-1:0] per_val_i,
  output logic             refill_o
);
  logic [PER_W-1:0] per_q, cnt_q, cnt_d;

  always_comb begin
    if (refill_o) cnt_d = (per_q == '0) ? '0 : per_q - 1'b1;
    else          cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        per_q <= PER_W'(DEF_PERIOD);
    else if (per_wr_i) per_q <= per_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= PER_W'(DEF_PERIOD - 1);
    else        cnt_q <= cnt_d;
  end

  assign refill_o = (cnt_q == '0);

  assert_gap_after_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_o && per_q > 1) |=> !refill_o);
endmodule

// File: rtl/tram_alloc_mgr.sv
module tram_alloc_mgr
  import tram_pkg::*;
#(
  parameter int NUM_REQ    = 4,
  parameter int NUM_IO     = 2,
  parameter int BUD_W      = 4,
  parameter int PER_W      = 8,
  parameter int DEF_ALLOC  = 2,
  parameter int DEF_PERIOD = 16,
  localparam int GRP_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int ADDR_W    = 1 + GRP_W + RES_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       req_valid_i,
  input  logic [NUM_REQ*RES_W-1:0] req_res_i,
  output logic [NUM_REQ-1:0]       req_gnt_o,
  output logic [NUM_REQ-1:0]       req_err_o,
  input  logic                     cfg_we_i,
  input  logic [ADDR_W-1:0]        cfg_addr_i,
  input  logic [PER_W-1:0]         cfg_wdata_i,
  input  logic                     ret_valid_i,
  input  logic [GRP_W-1:0]         ret_grp_i,
  input  logic [RES_W-1:0]         ret_res_i
);
  localparam int NUM_RES = BANKS + NUM_IO;

  logic                       refill;
  logic                       per_wr;
  logic [NUM_REQ*NUM_RES-1:0] avail;
  logic [NUM_RES*NUM_REQ-1:0] arb_gnt;

  assign per_wr = cfg_we_i && cfg_addr_i[ADDR_W-1];

  tram_period_timer #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .per_wr_i(per_wr), .per_val_i(cfg_wdata_i),
    .refill_o(refill)
  );

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    logic [NUM_REQ-1:0] rq;
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_grp
      logic cfg_hit, give;
      assign rq[i] = req_valid_i[i] && avail[i*NUM_RES+r] &&
                     (req_res_i[i*RES_W +: RES_W] == RES_W'(r));
      assign cfg_hit = cfg_we_i && !cfg_addr_i[ADDR_W-1] &&
                       (cfg_addr_i[RES_W +: GRP_W] == GRP_W'(i)) &&
                       (cfg_addr_i[RES_W-1:0] == RES_W'(r));
      assign give = ret_valid_i && (ret_grp_i == GRP_W'(i)) &&
                    (ret_res_i == RES_W'(r));
      tram_budget_slot #(.BUD_W(BUD_W), .DEF_ALLOC(DEF_ALLOC)) u_slot (
        .clk(clk), .rst_n(rst_n), .refill_i(refill),
        .cfg_hit_i(cfg_hit), .cfg_val_i(cfg_wdata_i[BUD_W-1:0]),
        .take_i(arb_gnt[r*NUM_REQ+i]), .give_i(give),
        .avail_o(avail[i*NUM_RES+r])
      );
    end
    tram_rr_arb #(.N(NUM_REQ)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(rq),
      .gnt_o(arb_gnt[r*NUM_REQ +: NUM_REQ])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      req_gnt_o[i] = 1'b0;
      for (int r = 0; r < NUM_RES; r++) req_gnt_o[i] = req_gnt_o[i] | arb_gnt[r*NUM_REQ+i];
      req_err_o[i] = req_valid_i[i] && (int'(req_res_i[i*RES_W +: RES_W]) >= NUM_RES);
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
    assert_error_blocks_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_err_o[i] |-> !req_gnt_o[i]);
    assert_grant_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_gnt_o[i] |-> req_valid_i[i]);
  end
endmodule

// File: tb/tram_alloc_mgr_bench.sv
module tram_alloc_mgr_bench;
  localparam int NR = 4;
  logic clk = 1'b0;
  logic rst_n;
  logic [NR-1:0]   rv;
  logic [NR*5-1:0] rres;
  logic [NR-1:0]   gnt, err;
  logic            cfg_we;
  logic [7:0]      cfg_addr;
  logic [7:0]      cfg_wdata;
  logic            ret_v;
  logic [1:0]      ret_g;
  logic [4:0]      ret_r;

  int checks = 0, errors = 0;
  int gcnt [NR];
  int ecnt [NR];
  int mcnt, mpend;
  logic mbnd;

  always #5 clk = ~clk;

  tram_alloc_mgr u_tram_alloc_mgr (
    .clk(clk), .rst_n(rst_n), .req_valid_i(rv), .req_res_i(rres),
    .req_gnt_o(gnt), .req_err_o(err), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .ret_valid_i(ret_v), .ret_grp_i(ret_g), .ret_res_i(ret_r)
  );

  // refill timing model derived from R1, R8 and R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= 15; mpend <= 16; mbnd <= 1'b0;
    end else begin
      mbnd <= (mcnt == 0);
      if (cfg_we && cfg_addr[7]) mpend <= int'(cfg_wdata);
      if (mcnt == 0) mcnt <= (mpend == 0) ? 0 : mpend - 1;
      else           mcnt <= mcnt - 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync();
    do @(negedge clk); while (!mbnd);
  endtask

  task automatic set_req(input int g, input int res);
    rv[g] = 1'b1;
    rres[g*5 +: 5] = 5'(res);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < NR; i++) begin gcnt[i] = 0; ecnt[i] = 0; end
    for (int c = 0; c < n; c++) begin
      #1;
      for (int i = 0; i < NR; i++) begin
        if (gnt[i]) gcnt[i]++;
        if (err[i]) ecnt[i]++;
      end
      @(negedge clk);
    end
    rv = '0;
  endtask

  task automatic cfg_write(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic give_back(input int g, input int res);
    ret_v = 1'b1; ret_g = 2'(g); ret_r = 5'(res);
    @(negedge clk);
    ret_v = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rv = '0; rres = '0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; ret_v = 1'b0; ret_g = '0; ret_r = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs, then reset budget of 2 inside the first period
    #1;
    check("R1 idle grants", int'(gnt), 0);
    check("R1 idle errors", int'(err), 0);
    @(negedge clk);
    set_req(2, 9); run(3);
    check("R1 reset budget", gcnt[2], 2);

    // R4: four groups on bank 5, rotation 0,1,2,3,0,1,2,3 then empty
    sync();
    for (int g = 0; g < NR; g++) set_req(g, 5);
    for (int c = 0; c < 9; c++) begin
      #1;
      check($sformatf("R4 rotation cycle %0d", c), int'(gnt), (c < 8) ? (1 << (c % 4)) : 0);
      @(negedge clk);
    end
    rv = '0;

    // R5: four resources granted together
    sync();
    set_req(0, 1); set_req(1, 2); set_req(2, 16); set_req(3, 17);
    #1;
    check("R5 parallel grants", int'(gnt), 15);
    @(negedge clk); rv = '0;

    // R2: every valid index yields exactly the allocation per period
    for (int r = 0; r < 18; r++) begin
      sync();
      set_req(r % 4, r); run(4);
      check($sformatf("R2 index %0d grants", r), gcnt[r % 4], 2);
      check($sformatf("R2 index %0d no error", r), ecnt[r % 4], 0);
    end

    // R3 / R10: held request waits across a refill
    sync();
    set_req(3, 12); run(20);
    check("R3 R10 held across refill", gcnt[3], 4);
    check("R3 no error while waiting", ecnt[3], 0);

    // R6: out-of-range indices
    for (int x = 18; x < 32; x++) begin
      set_req(0, x); run(1);
      check($sformatf("R6 index %0d error", x), ecnt[0], 1);
      check($sformatf("R6 index %0d no grant", x), gcnt[0], 0);
    end

    // R7: allocation write deferred to next refill
    sync();
    cfg_write(0 * 32 + 7, 5);
    set_req(0, 7); run(8);
    check("R7 old allocation kept", gcnt[0], 2);
    sync();
    set_req(0, 7); set_req(1, 7); run(8);
    check("R7 new allocation", gcnt[0], 5);
    check("R7 other group unaffected", gcnt[1], 2);
    cfg_write(0 * 32 + 7, 0);
    sync();
    set_req(0, 7); run(8);
    check("R7 zero allocation", gcnt[0], 0);

    // R8: period change and zero period
    sync();
    cfg_write(128, 6);
    sync();
    set_req(2, 3); run(14);
    check("R8 period of 6", gcnt[2], 6);
    cfg_write(128, 0);
    sync();
    set_req(2, 3); run(4);
    check("R8 period of 0 as 1", gcnt[2], 4);
    cfg_write(128, 40);
    sync();

    // R9: returns refund tokens, capped at the allocation
    set_req(1, 16); run(3);
    check("R9 drain", gcnt[1], 2);
    give_back(1, 16);
    set_req(1, 16); run(2);
    check("R9 single refund", gcnt[1], 1);
    give_back(1, 16); give_back(1, 16); give_back(1, 16);
    set_req(1, 16); run(3);
    check("R9 refund saturates", gcnt[1], 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule